// File: doc/BRIEF.md
# Scaled Four-Stage CIC Decimator

The block is a four-stage cascaded integrator-comb decimator with a programmable pre-scaling shifter in front of it. It accepts one 22-bit signed sample on every clock. It emits one result every N clocks, where N is the programmed decimation value plus one. The pre-scaler shifts the sample left by `scale` bits inside a fixed 66-bit datapath. Software picks `scale` so that the filter's N^4 DC growth lands just below the top of that path, which gives the most headroom without overflow.

The four integrators run at the input rate and use wrap-around two's-complement arithmetic. The four combs run at the decimated rate, each with a differential delay of one. The output is the upper 24 bits of the 66-bit comb result, which is the same as shifting the result right arithmetically by 42. When `N^4 * 2^scale = 2^44`, a full-scale input therefore maps to a full-scale output, with two extra fraction bits for the gain stage that follows. Both configuration inputs are captured only while the filter is held in reset.

Top module: `cic4_decim`

## Requirements
- R1: While rst_ni is low, and afterwards until the first output strobe, valid_o is 0 and data_o is 0.
- R2: valid_o is a one-cycle strobe. After reset is released it rises first in the N-th clock, then once every N clocks, where N = dec_i + 1 as captured during reset.
- R3: data_o is bits [65:42] of the 66-bit result x * 2^scale * N^4. For N = 4 and scale = 36, a constant input x settles to data_o = 4x. This holds for positive, negative and both full-scale inputs.
- R4: For a decimation factor that is not a power of two, the settled output for constant x is (x * N^4 * 2^scale) >> 42, which is below the unity value 4x. For N = 3, scale = 37 and x = 3200, data_o = 8100.
- R5: After a single input impulse of amplitude A, the outputs sum to (A * N^3 * 2^scale) >> 42. For N = 4, scale = 40 and A = 400, the sum is 6400.
- R6: With dec_i = 0 (N = 1), an output is produced on every clock and settles to (x * 2^scale) >> 42.
- R7: A scale_i value above 40 is treated as 40.
- R8: dec_i and scale_i are sampled only while rst_ni is low. Changes made while running do not alter the output period or the output values until the next reset.
- R9: data_o holds its value in every cycle in which valid_o is low.
- R10: The integrators wrap without error. With N = 2048 and scale = 0, a constant input x, including -2^21, settles to data_o = 4x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one input sample per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset; configuration is captured while it is low |
| x_i | input | 22 | Signed input sample |
| dec_i | input | 11 | Decimation value; N = dec_i + 1 |
| scale_i | input | 6 | Pre-scaler left shift, 0 to 40, larger values clamp to 40 |
| data_o | output | 24 | Signed result, bits [65:42] of the comb output |
| valid_o | output | 1 | One-cycle strobe marking a new data_o |

## Verification
The bound checker watches four timing properties on every cycle:
- the strobe period, checked against a counter of cycles since the last strobe;
- data_o holding still between strobes;
- data_o staying at zero before the first strobe;
- the captured configuration staying frozen while the filter runs.

Numeric correctness can only be shown by the bench scenarios. These cover the settled DC values for power-of-two and other factors, the impulse sum across the polyphase outputs, the scale clamp, the pass-through case N = 1, and integrator wrap at the largest N. They also show that changing the configuration inputs while running has no effect.

// File: rtl/cic4_pkg.sv
package cic4_pkg;
  localparam int unsigned IN_W      = 22;
  localparam int unsigned ACC_W     = 66;
  localparam int unsigned OUT_W     = 24;
  localparam int unsigned STAGES    = 4;
  localparam int unsigned DEC_W     = 11;
  localparam int unsigned SCALE_W   = 6;
  localparam int unsigned MAX_SCALE = 40;
endpackage

// File: rtl/cic4_prescale.sv
module cic4_prescale #(
  parameter int unsigned IN_W    = 22,
  parameter int unsigned ACC_W   = 66,
  parameter int unsigned SCALE_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  x_i,
  input  logic [SCALE_W-1:0]      scale_i,
  output logic signed [ACC_W-1:0] y_o
);
  logic signed [ACC_W-1:0] ext_w;
  assign ext_w = {{(ACC_W-IN_W){x_i[IN_W-1]}}, x_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_o <= '0;
    else         y_o <= ext_w <<< scale_i;
  end
endmodule

// File: rtl/cic4_integ.sv
module cic4_integ #(
  parameter int unsigned W = 66
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] in_i,
  output logic signed [W-1:0] acc_o
);
  // modulo-2^W accumulate; wrap is harmless, the combs undo it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_o <= '0;
    else         acc_o <= acc_o + in_i;
  end
endmodule

// File: rtl/cic4_comb.sv
module cic4_comb #(
  parameter int unsigned W      = 66,
  parameter int unsigned KEEP_W = 66
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [W-1:0]      in_i,
  output logic signed [KEEP_W-1:0] out_o
);
  logic signed [W-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dly_q <= '0;
    else if (en_i) dly_q <= in_i;
  end

  if (KEEP_W == W) begin : g_full
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   out_o <= '0;
      else if (en_i) out_o <= in_i - dly_q;
    end
  end else begin : g_trunc
    // only the top KEEP_W bits are kept; the low part supplies just the borrow
    localparam int unsigned LO = W - KEEP_W;
    logic borrow_w;
    assign borrow_w = in_i[LO-1:0] < dly_q[LO-1:0];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   out_o <= '0;
      else if (en_i) out_o <= in_i[W-1:LO] - dly_q[W-1:LO] - KEEP_W'(borrow_w);
    end
  end
endmodule

// File: rtl/cic4_tick.sv
module cic4_tick #(
  parameter int unsigned DEC_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEC_W-1:0] last_i,
  output logic             tick_o
);
  logic [DEC_W-1:0] cnt_q;
  assign tick_o = (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cic4_decim.sv
module cic4_decim
  import cic4_pkg::*;
#(
  parameter int unsigned P_IN_W      = IN_W,
  parameter int unsigned P_ACC_W     = ACC_W,
  parameter int unsigned P_OUT_W     = OUT_W,
  parameter int unsigned P_STAGES    = STAGES,
  parameter int unsigned P_DEC_W     = DEC_W,
  parameter int unsigned P_SCALE_W   = SCALE_W,
  parameter int unsigned P_MAX_SCALE = MAX_SCALE
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic signed [P_IN_W-1:0]  x_i,
  input  logic [P_DEC_W-1:0]        dec_i,
  input  logic [P_SCALE_W-1:0]      scale_i,
  output logic signed [P_OUT_W-1:0] data_o,
  output logic                      valid_o
);
  localparam logic [P_SCALE_W-1:0] SCALE_LIM = P_SCALE_W'(P_MAX_SCALE);

  logic [P_DEC_W-1:0]   dec_q;
  logic [P_SCALE_W-1:0] scale_q;
  logic [P_SCALE_W-1:0] scale_lim_w;
  logic                 tick_w;
  logic                 valid_q;

  assign scale_lim_w = (scale_i > SCALE_LIM) ? SCALE_LIM : scale_i;

  // configuration is captured only while the filter is held in reset
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      dec_q   <= dec_i;
      scale_q <= scale_lim_w;
    end
  end

  logic signed [P_ACC_W-1:0] integ_s [P_STAGES+1];
  logic signed [P_ACC_W-1:0] comb_s  [P_STAGES];
  logic signed [P_OUT_W-1:0] res_s;

  cic4_prescale #(.IN_W(P_IN_W), .ACC_W(P_ACC_W), .SCALE_W(P_SCALE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (x_i),
    .scale_i(scale_q),
    .y_o    (integ_s[0])
  );

  for (genvar g = 0; g < P_STAGES; g++) begin : g_integ
    cic4_integ #(.W(P_ACC_W)) u_integ (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (integ_s[g]),
      .acc_o (integ_s[g+1])
    );
  end

  cic4_tick #(.DEC_W(P_DEC_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .last_i(dec_q),
    .tick_o(tick_w)
  );

  assign comb_s[0] = integ_s[P_STAGES];

  for (genvar g = 0; g < P_STAGES - 1; g++) begin : g_comb
    cic4_comb #(.W(P_ACC_W), .KEEP_W(P_ACC_W)) u_comb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (tick_w),
      .in_i  (comb_s[g]),
      .out_o (comb_s[g+1])
    );
  end

  cic4_comb #(.W(P_ACC_W), .KEEP_W(P_OUT_W)) u_comb_last (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tick_w),
    .in_i  (comb_s[P_STAGES-1]),
    .out_o (res_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= tick_w;
  end

  assign data_o  = res_s;
  assign valid_o = valid_q;
endmodule

// File: rtl/cic4_decim_chk.sv
module cic4_decim_chk #(
  parameter int unsigned DEC_W   = 11,
  parameter int unsigned OUT_W   = 24,
  parameter int unsigned SCALE_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [OUT_W-1:0]   data_i,
  input logic [DEC_W-1:0]   dec_i,
  input logic [SCALE_W-1:0] scale_i
);
  logic [DEC_W:0] gap_q;
  logic [DEC_W:0] n_w;
  logic           seen_q;

  assign n_w = {1'b0, dec_i} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= valid_i ? {{DEC_W{1'b0}}, 1'b1} : gap_q + 1'b1;
      seen_q <= seen_q | valid_i;
    end
  end

  a_r2_strobe_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i == (gap_q == n_w));

  a_r1_zero_before_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && !valid_i) |-> (data_i == '0));

  a_r9_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(data_i));

  a_r8_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(dec_i) && $stable(scale_i));
endmodule

bind cic4_decim cic4_decim_chk #(
  .DEC_W  (P_DEC_W),
  .OUT_W  (P_OUT_W),
  .SCALE_W(P_SCALE_W)
) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_o),
  .data_i (data_o),
  .dec_i  (dec_q),
  .scale_i(scale_q)
);

// File: tb/cic4_decim_tb_top.sv
module cic4_decim_tb_top;
  logic               clk = 1'b0;
  logic               rst_n;
  logic signed [21:0] x;
  logic [10:0]        dec;
  logic [5:0]         scale;
  logic signed [23:0] data;
  logic               valid;

  always #4 clk = ~clk;

  cic4_decim dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .x_i    (x),
    .dec_i  (dec),
    .scale_i(scale),
    .data_o (data),
    .valid_o(valid)
  );

  int     n_tests = 0;
  int     n_fail  = 0;
  longint exp_q[$];
  string  tag_q[$];
  bit     mon_en = 0;
  bit     sum_en = 0;
  longint sum_acc = 0;
  int     exp_n = 1;
  longint cyc = 0;
  longint last_cyc = 0;
  bit     have_last = 0;
  bit     prev_ok = 0;
  longint prev_data = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // x * n^pw * 2^min(s,40), then arithmetic shift by 42 (bits 65:42)
  function automatic longint exp_gain(input longint xv, input int n, input int pw, input int s);
    logic signed [127:0] p;
    int se;
    se = (s > 40) ? 40 : s;
    p = xv;
    for (int k = 0; k < pw; k++) p = p * n;
    p = p <<< se;
    p = p >>> 42;
    return longint'(p);
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (valid) begin
        if (have_last) chk(cyc - last_cyc == exp_n, "R2 period", cyc - last_cyc, exp_n);
        last_cyc  = cyc;
        have_last = 1;
        if (sum_en) sum_acc += longint'(data);
        if (mon_en && exp_q.size() > 0) begin
          longint e;
          string  t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(longint'(data) == e, t, longint'(data), e);
        end
      end else if (prev_ok) begin
        chk(longint'(data) == prev_data, "R9 hold", longint'(data), prev_data);
      end
      prev_data = longint'(data);
      prev_ok   = 1;
    end
  end

  task automatic do_reset(input int d, input int s);
    @(posedge clk); #2;
    rst_n   = 1'b0;
    dec     = 11'(d);
    scale   = 6'(s);
    x       = '0;
    prev_ok = 0;
    have_last = 0;
    exp_n   = d + 1;
    repeat (4) @(posedge clk);
    #2;
    chk(valid == 1'b0 && data == '0, "R1 in reset", longint'(data), 0);
    rst_n     = 1'b1;
    last_cyc  = cyc + 1;
    have_last = 1;
    if (d >= 1) begin
      @(posedge clk); #2;
      chk(valid == 1'b0 && data == '0, "R1 after release", longint'(data), 0);
    end
  endtask

  task automatic drive_dc(input longint xv, input int n, input int s, input string tag);
    @(posedge clk); #2;
    x = 22'(xv);
    repeat (8 * n + 8) @(posedge clk);
    #2;
    for (int k = 0; k < 3; k++) begin
      exp_q.push_back(exp_gain(xv, n, 4, s));
      tag_q.push_back(tag);
    end
    mon_en = 1;
    while (exp_q.size() > 0) @(posedge clk);
    #2;
    mon_en = 0;
  endtask

  task automatic impulse(input longint a, input int n, input int s);
    @(posedge clk); #2;
    sum_acc = 0;
    sum_en  = 1;
    x = 22'(a);
    @(posedge clk); #2;
    x = '0;
    repeat (20 * n + 10) @(posedge clk);
    #2;
    sum_en = 0;
    chk(sum_acc == exp_gain(a, n, 3, s), "R5 impulse sum", sum_acc, exp_gain(a, n, 3, s));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; x = '0; dec = 11'd3; scale = 6'd36;
    // R3: N=4, scale 36 is unity
    do_reset(3, 36);
    drive_dc(1000, 4, 36, "R3 dc +1000");
    drive_dc(-(64'sd1 <<< 21), 4, 36, "R3 dc -fullscale");
    drive_dc((64'sd1 <<< 21) - 1, 4, 36, "R3 dc +fullscale");
    // R8: inputs changed while running are ignored
    @(posedge clk); #2;
    dec = 11'd9; scale = 6'd0;
    drive_dc(-500, 4, 36, "R8 cfg ignored");
    // R5: impulse response sums to A*N^3 scaled
    do_reset(3, 40);
    impulse(400, 4, 40);
    impulse(-1000, 4, 40);
    // R7: scale above 40 clamps
    do_reset(3, 63);
    drive_dc(400, 4, 63, "R7 scale clamp");
    // R4: N=3 below unity
    do_reset(2, 37);
    drive_dc(3200, 3, 37, "R4 n3 dc");
    chk(exp_gain(3200, 3, 4, 37) < 4 * 3200, "R4 below unity", exp_gain(3200, 3, 4, 37), 4 * 3200);
    // R6: N=1 pass-through
    do_reset(0, 40);
    drive_dc(-4000, 1, 40, "R6 n1 dc");
    // R10: integrators wrap at N=2048
    do_reset(2047, 0);
    drive_dc(-(64'sd1 <<< 21), 2048, 0, "R10 wrap -fullscale");
    drive_dc(12345, 2048, 0, "R10 wrap +12345");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule